// File: doc/BRIEF.md
# Programmable 16/32-bit CRC Engine

This block is a register-mapped checksum engine. It has three registers: a checksum register that also takes seeds, a polynomial register and a mode register. Software picks the checksum width (16 or 32 bits) and says whether writes to the checksum register load a seed or carry message bytes. In seed mode, each enabled byte lane of a write replaces the matching byte of the running checksum at once. In data mode, the enabled lanes are queued and folded into the checksum one byte per clock, most significant bit first. The fold uses a generic shift-register divider driven by the programmed polynomial. No reflection and no final inversion are applied.

The upper half of the polynomial and the two upper seed bytes only matter in 32-bit mode. While 16-bit mode is selected, writes to them are dropped, and a read of the checksum register shows only the low 16 bits. While queued bytes are still being consumed, the engine raises `busy` and discards every register write.

Top module: `crc_engine`

## Requirements
- R1: After reset the checksum reads 0x0000_0000, the polynomial reads 0x0000_1021, the mode register reads 0 and `busy` is low.
- R2: Register select `bus_addr` 0 is the checksum, 1 is the polynomial and 2 is the mode register. Mode bit 0 selects the width (0 = 16-bit, 1 = 32-bit) and mode bit 1 selects seed loading (1) or data feeding (0). A mode read returns only these two bits, with zeros above.
- R3: In 32-bit seed mode, a checksum write replaces byte n of the checksum (bits 8n+7:8n) for each set `bus_be[n]` and leaves the other bytes unchanged. It does not raise `busy`.
- R4: In 16-bit seed mode, lanes 0 and 1 load seed bytes and lanes 2 and 3 are discarded, so checksum bits 31:16 keep their value.
- R5: In data mode, every enabled lane is consumed, in both widths. One lane is consumed per clock, starting at the highest enabled lane and ending at the lowest. `busy` is high for exactly as many cycles as there are enabled lanes.
- R6: Each byte is folded most significant bit first with no reflection and no final XOR. With seed 0xFFFF and polynomial 0x1021, the ASCII string "123456789" gives 0x29B1. With seed 0xFFFFFFFF and polynomial 0x04C11DB7 it gives 0x0376E6E7.
- R7: Polynomial bits 15:0 are written in either width. Writes to bits 31:16 take effect only in 32-bit mode and are discarded in 16-bit mode.
- R8: In 16-bit mode, a checksum read returns the result in bits 15:0 and zeros in bits 31:16.
- R9: While `busy` is high, writes to any register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select for both read and write |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| busy | output | 1 | High while queued data bytes remain |

## Verification
The bench writes with sparse enables such as lanes 2 and 0 only. An engine that walked the lanes upward, or that consumed disabled lanes, would then end on a different checksum and hold `busy` for the wrong number of cycles. Seed bytes and polynomial bits are written into the gated upper halves while 16-bit mode is active, and the bench then switches to 32-bit mode to read back what survived, so a gate that leaks shows up at the port. Register writes are also issued while bytes are still queued, to catch an engine that accepts them. The two standard check strings, run in both widths, expose bit-order or feedback-tap mistakes.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int LANE_W   = 8;
  localparam int CRC_W    = 32;
  localparam int HALF_W   = CRC_W / 2;

  typedef enum logic [1:0] {
    SEL_SUM  = 2'd0,
    SEL_POLY = 2'd1,
    SEL_MODE = 2'd2
  } reg_sel_e;

  // One shift of the divider: message bit d enters at the top of the
  // active width; the 16-bit result always has zero upper half.
  function automatic logic [CRC_W-1:0] crc_bit(
    input logic [CRC_W-1:0] c,
    input logic             d,
    input logic [CRC_W-1:0] poly,
    input logic             wide
  );
    logic fb;
    logic [CRC_W-1:0] r;
    if (wide) begin
      fb = c[CRC_W-1] ^ d;
      r  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end else begin
      fb = c[HALF_W-1] ^ d;
      r  = {{HALF_W{1'b0}}, c[HALF_W-2:0], 1'b0}
         ^ {{HALF_W{1'b0}}, (fb ? poly[HALF_W-1:0] : {HALF_W{1'b0}})};
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_pkg::*;
#(
  parameter int BYTE_W = LANE_W
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [CRC_W-1:0]  poly,
  input  logic              wide,
  output logic [CRC_W-1:0]  crc_out
);

  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign stage[0] = crc_in;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    assign stage[g+1] = crc_bit(stage[g], byte_in[BYTE_W-1-g], poly, wide);
  end

  assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/crc_lane_sched.sv
module crc_lane_sched #(
  parameter int NUM_LANES = 4,
  localparam int IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NUM_LANES-1:0] load_mask,
  output logic [NUM_LANES-1:0] pending,
  output logic [NUM_LANES-1:0] pick,
  output logic [IDX_W-1:0]     pick_idx,
  output logic                 busy
);

  assign busy = |pending;

  // Highest pending lane wins.
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (pending[i]) begin
        pick     = '0;
        pick[i]  = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (busy) begin
      pending <= pending & ~pick;
    end else if (load) begin
      pending <= load_mask;
    end
  end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int          NUM_LANES  = CRC_W / LANE_W,
  parameter logic [31:0] POLY_RESET = 32'h0000_1021,
  parameter logic [31:0] SUM_RESET  = 32'h0000_0000,
  localparam int DATA_W     = NUM_LANES * LANE_W,
  localparam int HALF_LANES = NUM_LANES / 2,
  localparam int IDX_W      = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [NUM_LANES-1:0] bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 busy
);

  logic [CRC_W-1:0]     sum_q;
  logic [CRC_W-1:0]     poly_q;
  logic [DATA_W-1:0]    data_q;
  logic                 wide_q;
  logic                 seed_q;

  // Named events for the checker.
  logic                 wr_ok;
  logic                 wr_sum, wr_poly, wr_mode;
  logic                 seed_load, data_load;
  logic [NUM_LANES-1:0] pending, pick, lane_fire, lane_keep;
  logic [IDX_W-1:0]     pick_idx;
  logic [LANE_W-1:0]    cur_byte;
  logic [CRC_W-1:0]     step_out, seed_next;

  assign wr_ok     = bus_wr && !busy;
  assign wr_sum    = wr_ok && (bus_addr == SEL_SUM);
  assign wr_poly   = wr_ok && (bus_addr == SEL_POLY);
  assign wr_mode   = wr_ok && (bus_addr == SEL_MODE);
  assign seed_load = wr_sum && seed_q;
  assign data_load = wr_sum && !seed_q;
  assign lane_fire = busy ? pick : '0;

  crc_lane_sched #(.NUM_LANES(NUM_LANES)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_load),
    .load_mask (bus_be),
    .pending   (pending),
    .pick      (pick),
    .pick_idx  (pick_idx),
    .busy      (busy)
  );

  assign cur_byte = data_q[pick_idx*LANE_W +: LANE_W];

  crc_byte_step #(.BYTE_W(LANE_W)) u_step (
    .crc_in  (sum_q),
    .byte_in (cur_byte),
    .poly    (poly_q),
    .wide    (wide_q),
    .crc_out (step_out)
  );

  // Seed merge: upper lanes only count in 32-bit mode.
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_seed
    assign lane_keep[l] = bus_be[l] && (wide_q || (l < HALF_LANES));
    assign seed_next[l*LANE_W +: LANE_W] =
      lane_keep[l] ? bus_wdata[l*LANE_W +: LANE_W] : sum_q[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= SUM_RESET;
      poly_q <= POLY_RESET;
      data_q <= '0;
      wide_q <= 1'b0;
      seed_q <= 1'b0;
    end else begin
      if (busy)           sum_q <= step_out;
      else if (seed_load) sum_q <= seed_next;
      if (data_load) data_q <= bus_wdata;
      if (wr_poly) begin
        poly_q[HALF_W-1:0] <= bus_wdata[HALF_W-1:0];
        if (wide_q) poly_q[CRC_W-1:HALF_W] <= bus_wdata[CRC_W-1:HALF_W];
      end
      if (wr_mode) begin
        wide_q <= bus_wdata[0];
        seed_q <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      SEL_SUM:  bus_rdata = wide_q ? sum_q : {{HALF_W{1'b0}}, sum_q[HALF_W-1:0]};
      SEL_POLY: bus_rdata = poly_q;
      SEL_MODE: bus_rdata = {{(DATA_W-2){1'b0}}, seed_q, wide_q};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
  parameter int NUM_LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [1:0]             bus_addr,
  input logic [NUM_LANES*8-1:0] bus_rdata,
  input logic                   busy,
  input logic                   wide,
  input logic                   seed,
  input logic [31:0]            poly,
  input logic [NUM_LANES-1:0]   pending,
  input logic [NUM_LANES-1:0]   lane_fire
);

  // R5: at most one lane consumed per clock
  a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_fire));

  // R5: every busy cycle retires exactly one pending lane
  a_r5_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(pending) + 1 == $countones($past(pending))));

  // R3: a seed write never starts processing
  a_r3_seed_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !busy && bus_addr == 2'd0 && seed) |=> !busy);

  // R7: upper polynomial half frozen in 16-bit mode
  a_r7_poly_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !wide) |=> $stable(poly[31:16]));

  // R8: 16-bit readback has a zero upper half
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && bus_addr == 2'd0) |-> (bus_rdata[31:16] == 16'h0));

  // R9: writes during processing leave the polynomial alone
  a_r9_poly_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(poly));

endmodule

bind crc_engine crc_engine_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .wide      (wide_q),
  .seed      (seed_q),
  .poly      (poly_q),
  .pending   (pending),
  .lane_fire (lane_fire)
);

// File: tb/crc_engine_test.sv
module crc_engine_test;

  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        busy;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  crc_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  // ---- behavioural reference model ----
  logic [7:0]  m_q[$];
  logic [31:0] m_sum, m_poly;
  logic        m_wide, m_seed;

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b,
                                           input logic [31:0] p, input logic w);
    logic [31:0] x;
    logic [15:0] y;
    if (w) begin
      x = c ^ {b, 24'h0};
      for (int k = 0; k < 8; k++) x = x[31] ? ((x << 1) ^ p) : (x << 1);
      return x;
    end
    y = c[15:0] ^ {b, 8'h0};
    for (int k = 0; k < 8; k++) y = y[15] ? ((y << 1) ^ p[15:0]) : (y << 1);
    return {16'h0, y};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_sum = 32'h0; m_poly = 32'h1021; m_wide = 1'b0; m_seed = 1'b0;
    end else if (m_q.size() != 0) begin
      m_sum = ref_step(m_sum, m_q.pop_front(), m_poly, m_wide);
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: if (m_seed) begin
                for (int l = 0; l < 4; l++)
                  if (bus_be[l] && (m_wide || l < 2)) m_sum[l*8 +: 8] = bus_wdata[l*8 +: 8];
              end else begin
                for (int l = 3; l >= 0; l--)
                  if (bus_be[l]) m_q.push_back(bus_wdata[l*8 +: 8]);
              end
        2'd1: begin
                m_poly[15:0] = bus_wdata[15:0];
                if (m_wide) m_poly[31:16] = bus_wdata[31:16];
              end
        2'd2: begin m_wide = bus_wdata[0]; m_seed = bus_wdata[1]; end
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_wide ? m_sum : {16'h0, m_sum[15:0]};
      2'd1: return m_poly;
      2'd2: return {30'h0, m_seed, m_wide};
      default: return 32'h0;
    endcase
  endfunction

  // ---- every-clock comparison ----
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (busy !== (m_q.size() != 0) || bus_rdata !== m_read(bus_addr)) begin
        failures++;
        $display("FAIL R5/R9 per-cycle: busy=%0b rdata=%h expected busy=%0b rdata=%h",
                 busy, bus_rdata, (m_q.size() != 0), m_read(bus_addr));
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic feed_string;
    int n;
    wr(2'd0, 32'h31323334, 4'hF); drain(n);
    chk("R5 four lanes busy cycles", 32'(n), 32'd4);
    wr(2'd0, 32'h35363738, 4'hF); drain(n);
    wr(2'd0, 32'h00000039, 4'h1); drain(n);
    chk("R5 one lane busy cycles", 32'(n), 32'd1);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 checksum reset", v, 32'h0);
    rd(2'd1, v); chk("R1 polynomial reset", v, 32'h0000_1021);
    rd(2'd2, v); chk("R1 mode reset", v, 32'h0);
    chk("R1 busy reset", {31'h0, busy}, 32'h0);

    // R2 mode register width
    wr(2'd2, 32'hFFFF_FFFF, 4'hF);
    rd(2'd2, v); chk("R2 mode readback", v, 32'h3);

    // R6 32-bit known answer, R3 full seed
    wr(2'd1, 32'h04C1_1DB7, 4'hF);
    rd(2'd1, v); chk("R7 poly written in 32-bit", v, 32'h04C1_1DB7);
    wr(2'd0, 32'hFFFF_FFFF, 4'hF);
    chk("R3 seed no busy", {31'h0, busy}, 32'h0);
    rd(2'd0, v); chk("R3 full seed", v, 32'hFFFF_FFFF);
    wr(2'd2, 32'h1, 4'hF);
    feed_string();
    rd(2'd0, v); chk("R6 32-bit check string", v, 32'h0376_E6E7);

    // R3 partial seed lane
    wr(2'd2, 32'h3, 4'hF);
    wr(2'd0, 32'h0000_AB00, 4'h2);
    rd(2'd0, v); chk("R3 single lane seed", v, 32'h0376_ABE7);

    // R4 upper seed lanes dropped in 16-bit mode
    wr(2'd2, 32'h2, 4'hF);
    wr(2'd0, 32'h1122_3344, 4'hF);
    rd(2'd0, v); chk("R4 R8 16-bit seed readback", v, 32'h0000_3344);
    wr(2'd2, 32'h3, 4'hF);
    rd(2'd0, v); chk("R4 upper bytes kept", v, 32'h0376_3344);

    // R7 upper polynomial half dropped in 16-bit mode
    wr(2'd2, 32'h2, 4'hF);
    wr(2'd1, 32'h1234_1021, 4'hF);
    rd(2'd1, v); chk("R7 poly high kept", v, 32'h04C1_1021);

    // R6 16-bit known answer
    wr(2'd0, 32'h0000_FFFF, 4'hF);
    wr(2'd2, 32'h0, 4'hF);
    feed_string();
    rd(2'd0, v); chk("R6 R8 16-bit check string", v, 32'h0000_29B1);

    // R9 writes during processing ignored
    wr(2'd2, 32'h1, 4'hF);
    wr(2'd0, 32'h0102_0304, 4'hF);
    wr(2'd1, 32'hDEAD_BEEF, 4'hF);
    wr(2'd2, 32'h0, 4'hF);
    drain(n);
    rd(2'd1, v); chk("R9 poly unchanged", v, 32'h04C1_1021);
    rd(2'd2, v); chk("R9 mode unchanged", v, 32'h1);

    // R5 sparse lanes, high to low
    wr(2'd2, 32'h3, 4'hF);
    wr(2'd0, 32'h1234_5678, 4'hF);
    wr(2'd2, 32'h1, 4'hF);
    wr(2'd0, 32'hA1B2_C3D4, 4'h5);
    drain(n);
    chk("R5 sparse busy cycles", 32'(n), 32'd2);
    e = ref_step(ref_step(32'h1234_5678, 8'hB2, 32'h04C1_1021, 1'b1), 8'hD4, 32'h04C1_1021, 1'b1);
    rd(2'd0, v); chk("R5 sparse lane order", v, e);

    // R5 data lanes 2..3 feed in 16-bit mode too
    wr(2'd2, 32'h2, 4'hF);
    wr(2'd0, 32'h0000_FFFF, 4'hF);
    wr(2'd2, 32'h0, 4'hF);
    wr(2'd0, 32'h3132_0000, 4'hC);
    drain(n);
    e = ref_step(ref_step(32'h0000_FFFF, 8'h31, 32'h1021, 1'b0), 8'h32, 32'h1021, 1'b0);
    rd(2'd0, v); chk("R5 upper lanes feed in 16-bit", v, e);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule